// File: doc/BRIEF.md
# Ethernet Receive Framer with Packet Buffers

This block sits behind a double-data-rate input stage that has already been brought into one clock domain. Each cycle it sees the receive data-valid flag, the receive-error flag and either a full byte (gigabit) or a nibble on the low four data bits (10 and 100 Mb/s). It hunts for the start-of-frame delimiter, then stores every following byte, the frame check sequence included, into one of several fixed-size packet buffers. Bytes that arrive flagged as errored are discarded. A running CRC-32 is kept over the stored stream.

When the data-valid flag drops, the framer writes a 16-bit descriptor into a small notification FIFO. The descriptor names the buffer, gives the exact byte count and flags CRC and framing faults. A consumer pops descriptors and reads the packet bytes back through a one-cycle-latency read port. Two counters track carrier-indication cycles and frames lost because the FIFO was full.

Top module: `eth_rx_framer`

## Requirements
- R1: The preamble and the delimiter byte 0xD5 are never stored. The first byte after the delimiter lands at offset 0 of the selected buffer, which begins at address `buffer_number * BUF_BYTES`. The four FCS bytes are stored after the payload.
- R2: A frame is accepted with any number of preamble bytes, including none. A burst of data-valid that holds no 0xD5 byte creates no descriptor.
- R3: A byte received with data-valid and receive-error both high is not stored and is not counted in the length. It is left out of the CRC.
- R4: Descriptor layout: bit 15 = CRC error, bit 14 = frame error, bits 13:11 = buffer number, bits 10:0 = length. Buffer bytes appear on the read data output one clock after their address is presented.
- R5: The length field equals the number of bytes stored, FCS included.
- R6: Each cycle with data-valid low, receive-error high and a carrier code of 0x0E on the data bus increments the carrier counter by one. In nibble mode only the low nibble is compared, against 0xE. Such cycles create no descriptor.
- R7: A reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) runs over the stored bytes. A good frame leaves the register at 0xDEBB20E3. Any other value sets bit 15.
- R8: In nibble mode the low nibble arrives first and two nibbles form a byte. A frame that ends after an odd number of nibbles past the last complete byte sets bit 14.
- R9: Accepted frames take buffers in round-robin order 0,1,...,NUM_BUF-1 and then wrap to 0.
- R10: If the descriptor FIFO is full when a delimiter is seen, the frame is discarded and the overflow counter rises by one. The frame uses no buffer.
- R11: A frame longer than BUF_BYTES stores only its first BUF_BYTES bytes, reports length BUF_BYTES and sets bit 14.
- R12: Descriptors come out in arrival order. The valid output stays high and the data stays stable until popped, and valid is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| nibble_mode | input | 1 | 1 = 10/100 nibble transfers, 0 = byte transfers |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| rx_data | input | 8 | Receive data (low nibble only in nibble mode) |
| rd_addr | input | log2(NUM_BUF)+log2(BUF_BYTES) | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle after address |
| desc_valid | output | 1 | Descriptor FIFO not empty |
| desc_data | output | 16 | Head descriptor |
| desc_pop | input | 1 | Remove head descriptor |
| carrier_count | output | CNT_W | Carrier-indication cycle count |
| overflow_count | output | CNT_W | Frames dropped for a full FIFO |

## Verification
The bound checker watches several things on every cycle. The carrier counter must step exactly when the carrier pattern was on the inputs, and the overflow counter may only rise by one. A waiting descriptor must hold until it is popped, and no reported length may exceed a buffer. The bench covers behaviour that spans whole frames: hunting for the delimiter with short or missing preambles, dropping errored bytes, nibble pairing and odd endings, CRC verdicts, round-robin wrap, truncation of oversized frames and the drop when the FIFO is full. These are checked by reading descriptors and buffer contents back through the ports.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [7:0]  CARRIER_CODE  = 8'h0E;

  typedef struct packed {
    logic        crc_bad;
    logic        frame_bad;
    logic [2:0]  buf_id;
    logic [10:0] len;
  } rx_desc_t;

  // One byte of reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_rx_nibbler.sv
// Turns the per-cycle receive stream into a byte stream with an end marker.
module eth_rx_nibbler (
  input  logic       clk,
  input  logic       rst,
  input  logic       nibble_mode,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic [7:0] rx_data,
  output logic       b_vld,
  output logic [7:0] b_byte,
  output logic       b_err,
  output logic       b_end,
  output logic       b_odd
);
  logic       dv_q;
  logic       phase;
  logic       lo_er;
  logic [3:0] lo_nib;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_vld  <= 1'b0;
      b_byte <= 8'd0;
      b_err  <= 1'b0;
      b_end  <= 1'b0;
      b_odd  <= 1'b0;
      dv_q   <= 1'b0;
      phase  <= 1'b0;
      lo_er  <= 1'b0;
      lo_nib <= 4'd0;
    end else begin
      b_vld <= 1'b0;
      b_end <= 1'b0;
      b_odd <= 1'b0;
      dv_q  <= rx_dv;
      if (rx_dv) begin
        if (!nibble_mode) begin
          b_vld  <= 1'b1;
          b_byte <= rx_data;
          b_err  <= rx_er;
          phase  <= 1'b0;
        end else if (!phase) begin
          lo_nib <= rx_data[3:0];
          lo_er  <= rx_er;
          phase  <= 1'b1;
        end else begin
          b_vld  <= 1'b1;
          b_byte <= {rx_data[3:0], lo_nib};
          b_err  <= rx_er | lo_er;
          phase  <= 1'b0;
        end
      end else begin
        phase <= 1'b0;
        if (dv_q) begin
          b_end <= 1'b1;
          b_odd <= phase;
        end
      end
    end
  end
endmodule

// File: rtl/eth_rx_desc_fifo.sv
module eth_rx_desc_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             valid,
  output logic [WIDTH-1:0] data,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign valid   = (count != '0);
  assign data    = store[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/eth_rx_bufmem.sv
// Simple dual-port byte memory, registered read, block-RAM friendly.
module eth_rx_bufmem #(
  parameter int WORDS = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eth_rx_framer.sv
module eth_rx_framer #(
  parameter int NUM_BUF    = 8,
  parameter int BUF_BYTES  = 512,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          nibble_mode,
  input  logic                                          rx_dv,
  input  logic                                          rx_er,
  input  logic [7:0]                                    rx_data,
  input  logic [$clog2(NUM_BUF)+$clog2(BUF_BYTES)-1:0]  rd_addr,
  output logic [7:0]                                    rd_data,
  output logic                                          desc_valid,
  output logic [15:0]                                   desc_data,
  input  logic                                          desc_pop,
  output logic [CNT_W-1:0]                              carrier_count,
  output logic [CNT_W-1:0]                              overflow_count
);
  import eth_rx_pkg::*;

  localparam int BUF_W  = $clog2(NUM_BUF);
  localparam int OFF_W  = $clog2(BUF_BYTES);
  localparam int ADDR_W = BUF_W + OFF_W;
  localparam int LEN_W  = OFF_W + 1;

  typedef enum logic [1:0] {ST_HUNT, ST_RECV, ST_SKIP} fr_state_t;

  logic       b_vld, b_err, b_end, b_odd;
  logic [7:0] b_byte;

  fr_state_t        state;
  logic [BUF_W-1:0] buf_sel;
  logic [LEN_W-1:0] wcount;
  logic             too_long;
  logic [31:0]      crc;
  logic             fifo_full;
  logic             push;
  rx_desc_t         new_desc;
  logic             wr_en;
  logic             carrier_hit;
  logic             good_byte;

  eth_rx_nibbler u_nib (
    .clk, .rst, .nibble_mode, .rx_dv, .rx_er, .rx_data,
    .b_vld, .b_byte, .b_err, .b_end, .b_odd
  );

  assign good_byte = b_vld && !b_err;
  assign wr_en     = (state == ST_RECV) && good_byte && (wcount < LEN_W'(BUF_BYTES));
  assign push      = (state == ST_RECV) && b_end;

  always_comb begin
    new_desc           = '0;
    new_desc.crc_bad   = (crc != CRC_RESIDUE);
    new_desc.frame_bad = b_odd | too_long;
    new_desc.buf_id    = 3'(buf_sel);
    new_desc.len       = 11'(wcount);
  end

  assign carrier_hit = !rx_dv && rx_er &&
                       (nibble_mode ? (rx_data[3:0] == CARRIER_CODE[3:0])
                                    : (rx_data == CARRIER_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_HUNT;
      buf_sel        <= '0;
      wcount         <= '0;
      too_long       <= 1'b0;
      crc            <= '1;
      overflow_count <= '0;
      carrier_count  <= '0;
    end else begin
      if (carrier_hit) carrier_count <= carrier_count + 1'b1;
      if (b_end) begin
        state <= ST_HUNT;
        if (state == ST_RECV)
          buf_sel <= (buf_sel == BUF_W'(NUM_BUF-1)) ? '0 : buf_sel + 1'b1;
      end else begin
        case (state)
          ST_HUNT: if (good_byte && b_byte == SFD_BYTE) begin
            if (fifo_full) begin
              state          <= ST_SKIP;
              overflow_count <= overflow_count + 1'b1;
            end else begin
              state    <= ST_RECV;
              wcount   <= '0;
              too_long <= 1'b0;
              crc      <= '1;
            end
          end
          ST_RECV: if (good_byte) begin
            crc <= crc_step(crc, b_byte);
            if (wcount < LEN_W'(BUF_BYTES)) wcount <= wcount + 1'b1;
            else                            too_long <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  eth_rx_bufmem #(.WORDS(NUM_BUF*BUF_BYTES), .AW(ADDR_W)) u_mem (
    .clk,
    .we    (wr_en),
    .waddr ({buf_sel, wcount[OFF_W-1:0]}),
    .wdata (b_byte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  eth_rx_desc_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst,
    .push      (push),
    .push_data (new_desc),
    .pop       (desc_pop),
    .valid     (desc_valid),
    .data      (desc_data),
    .full      (fifo_full)
  );
endmodule

// File: rtl/eth_rx_framer_chk.sv
module eth_rx_framer_chk #(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             nibble_mode,
  input logic             rx_dv,
  input logic             rx_er,
  input logic [7:0]       rx_data,
  input logic             desc_valid,
  input logic [15:0]      desc_data,
  input logic             desc_pop,
  input logic [CNT_W-1:0] carrier_count,
  input logic [CNT_W-1:0] overflow_count
);
  logic carrier_in;
  assign carrier_in = !rx_dv && rx_er &&
                      (nibble_mode ? (rx_data[3:0] == 4'hE) : (rx_data == 8'h0E));

  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
    carrier_in |=> carrier_count == $past(carrier_count) + 1'b1); // R6
  AST_CARRIER_QUIET: assert property (@(posedge clk) disable iff (rst)
    !carrier_in |=> $stable(carrier_count)); // R6
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (rst)
    (overflow_count != $past(overflow_count)) |-> overflow_count == $past(overflow_count) + 1'b1); // R10
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> ({1'b0, desc_data[10:0]} <= 12'(BUF_BYTES))); // R11
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_pop) |=> desc_valid && $stable(desc_data)); // R12
endmodule

bind eth_rx_framer eth_rx_framer_chk #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .nibble_mode(nibble_mode), .rx_dv(rx_dv), .rx_er(rx_er),
  .rx_data(rx_data), .desc_valid(desc_valid), .desc_data(desc_data),
  .desc_pop(desc_pop), .carrier_count(carrier_count), .overflow_count(overflow_count)
);

// File: tb/sim_eth_rx_framer.sv
module sim_eth_rx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_BUF    = 8;
  localparam int BUF_BYTES  = 512;
  localparam int FIFO_DEPTH = 4;
  localparam int CNT_W      = 16;
  localparam int AW         = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nib = 1'b0;
  logic          rx_dv = 1'b0, rx_er = 1'b0;
  logic [7:0]    rx_data = 8'd0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          desc_valid;
  logic [15:0]   desc_data;
  logic          desc_pop = 1'b0;
  logic [CNT_W-1:0] carrier_count, overflow_count;

  int n_chk = 0;
  int n_err = 0;
  int exp_buf = 0;
  logic [7:0] frm [0:1023];
  int frm_len;
  logic [15:0] pend [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_framer #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES),
                  .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u0 (
    .clk, .rst, .nibble_mode(nib), .rx_dv, .rx_er, .rx_data,
    .rd_addr, .rd_data, .desc_valid, .desc_data, .desc_pop,
    .carrier_count, .overflow_count
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, frm[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [15:0] mk_desc(input bit bad, input bit ferr, input int b, input int len);
    return {bad, ferr, 3'(b), 11'(len)};
  endfunction

  task automatic mk_frame(input int plen);
    logic [31:0] f;
    for (int i = 0; i < plen; i++) frm[i] = 8'($urandom);
    f = ~ref_crc(plen);
    for (int k = 0; k < 4; k++) frm[plen+k] = f[8*k +: 8];
    frm_len = plen + 4;
  endtask

  task automatic put_cycle(input logic dv, input logic er, input logic [7:0] d);
    @(negedge clk);
    rx_dv = dv; rx_er = er; rx_data = d;
  endtask

  task automatic put_byte(input logic er, input logic [7:0] b);
    if (nib) begin
      put_cycle(1'b1, er, {4'h0, b[3:0]});
      put_cycle(1'b1, er, {4'h0, b[7:4]});
    end else begin
      put_cycle(1'b1, er, b);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put_cycle(1'b0, 1'b0, 8'd0);
  endtask

  task automatic send(input int npre, input int err_at, input bit odd_tail);
    for (int i = 0; i < npre; i++) put_byte(1'b0, 8'h55);
    put_byte(1'b0, 8'hD5);
    for (int i = 0; i < frm_len; i++) begin
      if (i == err_at) put_byte(1'b1, 8'hA5);
      put_byte(1'b0, frm[i]);
    end
    if (odd_tail) put_cycle(1'b1, 1'b0, 8'h03);
    idle(12);
  endtask

  task automatic pop();
    @(negedge clk); desc_pop = 1'b1;
    @(negedge clk); desc_pop = 1'b0;
  endtask

  task automatic verify_buf(input int b, input int n, input string req);
    int bad = 0;
    logic [7:0] first_act = 8'd0, first_exp = 8'd0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0 && rd_data !== frm[i-1]) begin
        if (bad == 0) begin first_act = rd_data; first_exp = frm[i-1]; end
        bad++;
      end
      if (i < n) rd_addr = AW'(b*BUF_BYTES + i);
    end
    chk(bad == 0, req, {24'd0, first_act}, {24'd0, first_exp});
  endtask

  task automatic expect_head(input logic [15:0] exp, input string req);
    chk(desc_valid === 1'b1, req, {31'd0, desc_valid}, 32'd1);
    chk(desc_data === exp, req, {16'd0, desc_data}, {16'd0, exp});
  endtask

  task automatic full_check(input logic [15:0] exp, input int nstore, input string req);
    expect_head(exp, req);
    verify_buf(exp_buf, nstore, req);
    pop();
    exp_buf = (exp_buf + 1) % NUM_BUF;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R12, R6, R10: reset state
    chk(desc_valid === 1'b0, "R12 reset", {31'd0, desc_valid}, 0);
    chk(carrier_count === '0 && overflow_count === '0, "R6 R10 reset",
        {carrier_count, overflow_count}, 0);

    // R1 R4 R5 R7: full preamble, good frame
    mk_frame(60); send(7, -1, 0);
    full_check(mk_desc(0, 0, exp_buf, 64), 64, "R1 R4 R5 R7 full preamble");

    // R2: delimiter only
    mk_frame(30); send(0, -1, 0);
    full_check(mk_desc(0, 0, exp_buf, 34), 34, "R2 no preamble");

    // R2: burst with no delimiter gives nothing
    for (int i = 0; i < 8; i++) put_byte(1'b0, 8'h55);
    idle(12);
    chk(desc_valid === 1'b0, "R2 no delimiter", {31'd0, desc_valid}, 0);

    // R7: corrupted byte after FCS computed
    mk_frame(50); frm[5] = frm[5] ^ 8'h10; send(3, -1, 0);
    full_check(mk_desc(1, 0, exp_buf, 54), 54, "R7 bad crc");

    // R3: errored byte dropped
    mk_frame(60); send(7, 10, 0);
    full_check(mk_desc(0, 0, exp_buf, 64), 64, "R3 error byte");

    // R6: carrier codes in byte mode
    for (int i = 0; i < 5; i++) put_cycle(1'b0, 1'b1, 8'h0E);
    for (int i = 0; i < 2; i++) put_cycle(1'b0, 1'b1, 8'h0F);
    idle(4);
    chk(carrier_count === 16'd5, "R6 carrier byte", {16'd0, carrier_count}, 5);
    chk(desc_valid === 1'b0, "R6 no descriptor", {31'd0, desc_valid}, 0);

    // R8: nibble mode
    nib = 1'b1;
    for (int i = 0; i < 3; i++) put_cycle(1'b0, 1'b1, 8'hFE);
    idle(4);
    chk(carrier_count === 16'd8, "R6 carrier nibble", {16'd0, carrier_count}, 8);
    mk_frame(40); send(3, -1, 0);
    full_check(mk_desc(0, 0, exp_buf, 44), 44, "R8 nibble frame");
    mk_frame(20); send(7, -1, 1);
    full_check(mk_desc(0, 1, exp_buf, 24), 24, "R8 odd nibble");
    nib = 1'b0;

    // R11: oversize
    mk_frame(600); send(7, -1, 0);
    full_check(mk_desc(0, 1, exp_buf, BUF_BYTES), BUF_BYTES, "R11 oversize");

    // R9: random frames through the wrap
    for (int f = 0; f < 12; f++) begin
      int plen, npre, ea;
      plen = 1 + int'($urandom % 120);
      npre = int'($urandom % 8);
      nib  = 1'($urandom);
      ea   = ($urandom % 3 == 0) ? int'($urandom % (plen + 4)) : -1;
      mk_frame(plen); send(npre, ea, 0);
      full_check(mk_desc(0, 0, exp_buf, plen + 4), plen + 4, "R9 R1 R5 random");
    end
    nib = 1'b0;

    // R10: FIFO full drops the fifth frame
    for (int f = 0; f < 5; f++) begin
      mk_frame(20 + f); send(2, -1, 0);
      pend[f] = mk_desc(0, 0, (exp_buf + f) % NUM_BUF, 24 + f);
    end
    chk(overflow_count === 16'd1, "R10 overflow count", {16'd0, overflow_count}, 1);
    for (int f = 0; f < 4; f++) begin
      expect_head(pend[f], "R10 R12 order");
      pop();
    end
    chk(desc_valid === 1'b0, "R10 dropped frame", {31'd0, desc_valid}, 0);
    exp_buf = (exp_buf + 4) % NUM_BUF;
    mk_frame(33); send(1, -1, 0);
    full_check(mk_desc(0, 0, exp_buf, 37), 37, "R10 R9 buffer not consumed");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule